// File: doc/BRIEF.md
# Masked Associative Lookup Memory with Per-Entry Validity Tags

This block is a 256-word by 64-bit associative memory. A search key is held in a key register and compared at once against every stored word whose two-bit tag marks it as live. The result is registered as a status: a hit flag, a flag for more than one hit, and the index of the lowest-numbered hitting word. Entries tagged as parked, unused or plain storage never take part in a search. Plain storage entries can still be read and written by index, so spare mask patterns can be kept in the array and fetched again when needed.

Two 64-bit pattern registers give per-bit control. A control word picks one pattern to hide bits from the search, and independently picks one pattern to guard bits against array writes. A coarse field in the control word also limits the search to the lowest 16-bit lanes. Bits outside the searched field act as payload, and that payload of the winning word can be read straight after a search. Writing the key, either pattern register or the control word starts a search by itself. A search can also be started by command.

Software reaches the block through one 64-bit bus with an enable, a write strobe (active low) and a command/data select (low for command). Command writes choose where data writes go and where data reads come from, set tags and start searches. Command reads return the status word.

Top module: `assoc_cam`

## Requirements
- R1: A synchronous reset (`rst` high) tags every entry unused, clears the key, both patterns, the status and the read register, and sets the control word to 0x40.
- R2: With `bus_en` high, the cycle type is decoded from `bus_wr_n`/`bus_cmd_n`: 0/0 command write, 0/1 data write, 1/0 command read (status), 1/1 data read. With `bus_en` low nothing changes. Read data appears on `bus_dout` one edge after the read cycle and holds until the next read. The status word is bits [7:0] index, bit 8 hit, bit 9 multi-hit, rest zero. Command writes use bits [3:0] opcode, [7:4] selector, [15:8] entry index, [17:16] tag. Opcode 1 sets the data-write destination, 2 sets the data-read source, 3 starts a search, 4 writes the tag. Other opcodes change nothing. Selector codes: 0 key, 1 pattern A, 2 pattern B, 3 control, 4 entry at the given index, 5 payload of the hit entry (read only). Unknown source codes read as zero.
- R3: Tag encoding is {parked, unused}: 00 live, 01 unused, 10 parked, 11 plain storage. Only live entries can hit.
- R4: A data write to the key, pattern A, pattern B or control starts a search. A data write to an entry does not.
- R5: Command opcode 3 starts a search with the registers as they stand.
- R6: The status changes only at the second rising edge after the bus cycle that starts a search. Otherwise it holds.
- R7: With several hits, the lowest index is reported and the multi-hit flag is set. The multi-hit flag is never set without the hit flag.
- R8: Control bit 0 enables search masking and bit 1 selects its pattern (0 = A, 1 = B). A pattern bit of 1 removes that bit position from the search.
- R9: Control bit 2 enables write guarding of entry writes and bit 3 selects its pattern (0 = A, 1 = B). A pattern bit of 1 keeps the stored bit unchanged.
- R10: Control bits [6:4] give the number of searched 16-bit lanes counted from bit 0 (values above 4 act as 4). With 0 lanes, every live entry hits.
- R11: A data read from source 5 returns the hit entry ANDed with the inverse of the current searched-bit set. It returns zero when the hit flag is clear.
- R12: Any entry, including plain storage entries, can be written through destination 4 and read through source 4 by index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus cycle enable |
| bus_wr_n | input | 1 | Low for write cycles, high for read cycles |
| bus_cmd_n | input | 1 | Low selects command, high selects data |
| bus_din | input | 64 | Write data or command word |
| bus_dout | output | 64 | Registered read data |
| match_o | output | 1 | Hit flag of the last search |
| multi_o | output | 1 | More than one entry hit |
| addr_o | output | 8 | Lowest hitting index |

## Verification
Searches run against identical words held at several indices under every tag value. This separates tag filtering from the lowest-index choice and from multi-hit detection. Words that differ only in upper lanes are searched with a top-lane pattern mask and then with a one-lane field. These runs show masking, lane limiting and payload extraction apart, because each leaves a different payload. Guarded entry writes are read back by index, including a plain storage entry. A long run of mixed random bus cycles over eight entries, checked against a cycle-level model every clock, tests trigger timing and read latency under back-to-back traffic.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int OP_W   = 4;
    localparam int SEL_W  = 4;
    localparam int TAG_W  = 2;
    localparam int SEGC_W = 3;
    localparam int CTRL_W = 7;

    typedef enum logic [OP_W-1:0] {
        OP_TARGET  = 4'd1,
        OP_SOURCE  = 4'd2,
        OP_COMPARE = 4'd3,
        OP_TAG     = 4'd4
    } op_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_KEY   = 4'd0,
        SEL_PAT_A = 4'd1,
        SEL_PAT_B = 4'd2,
        SEL_CTRL  = 4'd3,
        SEL_ENTRY = 4'd4,
        SEL_PAY   = 4'd5
    } sel_t;

    // {parked, unused}
    localparam logic [TAG_W-1:0] TAG_LIVE   = 2'b00;
    localparam logic [TAG_W-1:0] TAG_UNUSED = 2'b01;

    // control word bit positions
    localparam int CB_CMP_EN  = 0;
    localparam int CB_CMP_SEL = 1;
    localparam int CB_WR_EN   = 2;
    localparam int CB_WR_SEL  = 3;
    localparam int CB_SEG_LO  = 4;

    localparam logic [CTRL_W-1:0] CTRL_RST = 7'h40;
endpackage

// File: rtl/cam_cycle_dec.sv
module cam_cycle_dec (
    input  logic en,
    input  logic wr_n,
    input  logic cmd_n,
    output logic cmd_wr,
    output logic dat_wr,
    output logic cmd_rd,
    output logic dat_rd
);
    always_comb begin
        cmd_wr = en && !wr_n && !cmd_n;
        dat_wr = en && !wr_n &&  cmd_n;
        cmd_rd = en &&  wr_n && !cmd_n;
        dat_rd = en &&  wr_n &&  cmd_n;
    end
endmodule

// File: rtl/cam_store.sv
module cam_store import cam_pkg::*; #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_keep,
    input  logic              tag_we,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [TAG_W-1:0]  tag_val,
    input  logic [DATA_W-1:0] key,
    input  logic [DATA_W-1:0] care,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DEPTH-1:0]  hits
);
    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } tag_state_t;

    tag_state_t tag_d, tag_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        tag_d = tag_q;
        if (tag_we) tag_d.tag[tag_addr] = tag_val;
    end

    always_ff @(posedge clk) begin
        if (rst) tag_q.tag <= {DEPTH{TAG_UNUSED}};
        else     tag_q     <= tag_d;
    end

    // word storage: guarded bits keep their old value
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= (mem[wr_addr] & wr_keep) | (wr_data & ~wr_keep);
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hits[g] = (tag_q.tag[g] == TAG_LIVE) && (((mem[g] ^ key) & care) == '0);
    end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  hits,
    output logic              any,
    output logic              multi,
    output logic [ADDR_W-1:0] idx
);
    always_comb begin
        any   = |hits;
        multi = |(hits & (hits - DEPTH'(1)));
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hits[i]) idx = ADDR_W'(i);
        end
    end
endmodule

// File: rtl/assoc_cam.sv
module assoc_cam import cam_pkg::*; #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int NSEG   = DATA_W / SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr_n,
    input  logic              bus_cmd_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              match_o,
    output logic              multi_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int F_SEL  = OP_W;
    localparam int F_ADDR = OP_W + SEL_W;
    localparam int F_TAG  = F_ADDR + ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] key;
        logic [DATA_W-1:0] pat_a;
        logic [DATA_W-1:0] pat_b;
        logic [CTRL_W-1:0] ctrl;
        logic [SEL_W-1:0]  tgt;
        logic [ADDR_W-1:0] tgt_addr;
        logic [SEL_W-1:0]  src;
        logic [ADDR_W-1:0] src_addr;
        logic              pend;
        logic              match;
        logic              multi;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
    } regs_t;

    regs_t st_d, st_q;

    logic cmd_wr, dat_wr, cmd_rd, dat_rd;
    logic [DEPTH-1:0]  hits;
    logic              hit_any, hit_multi;
    logic [ADDR_W-1:0] hit_idx;
    logic [DATA_W-1:0] seg_care, care, excl, keep, rd_data;
    logic [SEGC_W-1:0] seg_raw, seg_n;
    logic [ADDR_W-1:0] rd_addr;
    logic              ent_we, tag_we;
    logic [DATA_W-1:0] stat_word, src_word;
    logic              cmp_pending, src_is_pay;

    cam_cycle_dec i_dec (
        .en(bus_en), .wr_n(bus_wr_n), .cmd_n(bus_cmd_n),
        .cmd_wr(cmd_wr), .dat_wr(dat_wr), .cmd_rd(cmd_rd), .dat_rd(dat_rd)
    );

    // searched lanes from the control word
    assign seg_raw = st_q.ctrl[CB_SEG_LO +: SEGC_W];
    assign seg_n   = (seg_raw > SEGC_W'(NSEG)) ? SEGC_W'(NSEG) : seg_raw;

    for (genvar g = 0; g < NSEG; g++) begin : g_lane
        assign seg_care[g*SEG_W +: SEG_W] = {SEG_W{SEGC_W'(g) < seg_n}};
    end

    assign excl = st_q.ctrl[CB_CMP_EN] ? (st_q.ctrl[CB_CMP_SEL] ? st_q.pat_b : st_q.pat_a) : '0;
    assign care = seg_care & ~excl;
    assign keep = st_q.ctrl[CB_WR_EN] ? (st_q.ctrl[CB_WR_SEL] ? st_q.pat_b : st_q.pat_a) : '0;

    assign ent_we  = dat_wr && (st_q.tgt == SEL_ENTRY);
    assign tag_we  = cmd_wr && (bus_din[OP_W-1:0] == OP_TAG);
    assign rd_addr = (st_q.src == SEL_PAY) ? st_q.addr : st_q.src_addr;

    cam_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst(rst),
        .wr_en(ent_we), .wr_addr(st_q.tgt_addr), .wr_data(bus_din), .wr_keep(keep),
        .tag_we(tag_we), .tag_addr(bus_din[F_ADDR +: ADDR_W]), .tag_val(bus_din[F_TAG +: TAG_W]),
        .key(st_q.key), .care(care),
        .rd_addr(rd_addr), .rd_data(rd_data), .hits(hits)
    );

    cam_prio #(.DEPTH(DEPTH)) i_prio (
        .hits(hits), .any(hit_any), .multi(hit_multi), .idx(hit_idx)
    );

    always_comb begin
        stat_word = '0;
        stat_word[ADDR_W-1:0] = st_q.addr;
        stat_word[ADDR_W]     = st_q.match;
        stat_word[ADDR_W+1]   = st_q.multi;
    end

    always_comb begin
        src_word = '0;
        case (st_q.src)
            SEL_KEY:   src_word = st_q.key;
            SEL_PAT_A: src_word = st_q.pat_a;
            SEL_PAT_B: src_word = st_q.pat_b;
            SEL_CTRL:  src_word[CTRL_W-1:0] = st_q.ctrl;
            SEL_ENTRY: src_word = rd_data;
            SEL_PAY:   src_word = st_q.match ? (rd_data & ~care) : '0;
            default:   src_word = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (st_q.pend) begin
            st_d.match = hit_any;
            st_d.multi = hit_multi;
            st_d.addr  = hit_idx;
        end
        if (cmd_rd) st_d.dout = stat_word;
        if (dat_rd) st_d.dout = src_word;
        if (cmd_wr) begin
            case (bus_din[OP_W-1:0])
                OP_TARGET: begin
                    st_d.tgt      = bus_din[F_SEL +: SEL_W];
                    st_d.tgt_addr = bus_din[F_ADDR +: ADDR_W];
                end
                OP_SOURCE: begin
                    st_d.src      = bus_din[F_SEL +: SEL_W];
                    st_d.src_addr = bus_din[F_ADDR +: ADDR_W];
                end
                OP_COMPARE: st_d.pend = 1'b1;
                default: ;
            endcase
        end
        if (dat_wr) begin
            case (st_q.tgt)
                SEL_KEY:   begin st_d.key   = bus_din; st_d.pend = 1'b1; end
                SEL_PAT_A: begin st_d.pat_a = bus_din; st_d.pend = 1'b1; end
                SEL_PAT_B: begin st_d.pat_b = bus_din; st_d.pend = 1'b1; end
                SEL_CTRL:  begin st_d.ctrl  = bus_din[CTRL_W-1:0]; st_d.pend = 1'b1; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_pending = st_q.pend;
    assign src_is_pay  = (st_q.src == SEL_PAY);

    assign bus_dout = st_q.dout;
    assign match_o  = st_q.match;
    assign multi_o  = st_q.multi;
    assign addr_o   = st_q.addr;
endmodule

// File: rtl/cam_chk.sv
module cam_chk import cam_pkg::*; #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr_n,
    input logic              bus_cmd_n,
    input logic [DATA_W-1:0] bus_din,
    input logic [DATA_W-1:0] bus_dout,
    input logic              match_o,
    input logic              multi_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              cmp_pending,
    input logic              src_is_pay
);
    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (!match_o && !multi_o && addr_o == '0 && bus_dout == '0));

    // R7
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        multi_o |-> match_o);

    // R6
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_pending |=> $stable({match_o, multi_o, addr_o}));

    // R2
    status_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr_n && !bus_cmd_n) |=>
        (bus_dout[ADDR_W+1:0] == $past({multi_o, match_o, addr_o}) && bus_dout[DATA_W-1:ADDR_W+2] == '0));

    // R5
    explicit_search_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr_n && !bus_cmd_n && bus_din[OP_W-1:0] == OP_COMPARE) |=> cmp_pending);

    // R11
    payload_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr_n && bus_cmd_n && src_is_pay && !match_o) |=> bus_dout == '0);
endmodule

bind assoc_cam cam_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr_n(bus_wr_n), .bus_cmd_n(bus_cmd_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .match_o(match_o), .multi_o(multi_o),
    .addr_o(addr_o), .cmp_pending(cmp_pending), .src_is_pay(src_is_pay)
);

// File: tb/test_assoc_cam.sv
`timescale 1ns/1ps
module test_assoc_cam;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, wr_n = 1'b1, cmd_n = 1'b1;
    logic [63:0] din = '0;
    logic [63:0] dout;
    logic        match_o, multi_o;
    logic [7:0]  addr_o;

    always #2.5 clk = ~clk;

    assoc_cam i_assoc_cam (
        .clk(clk), .rst(rst), .bus_en(en), .bus_wr_n(wr_n), .bus_cmd_n(cmd_n),
        .bus_din(din), .bus_dout(dout), .match_o(match_o), .multi_o(multi_o), .addr_o(addr_o)
    );

    int    checks = 0, fails = 0;
    bit    done = 1'b0;
    string phase = "R1 reset";

    // ---------------- reference model ----------------
    logic [63:0] m_mem [256];
    logic [1:0]  m_tag [256];
    logic [63:0] m_key, m_pa, m_pb, m_dout, m_care, m_keep;
    logic [6:0]  m_ctrl;
    logic [7:0]  m_addr;
    int          m_tgt, m_taddr, m_src, m_saddr, m_seg;
    bit          m_pend, m_match, m_multi, m_newpend, m_found;

    function automatic logic [63:0] model_care(logic [6:0] c, logic [63:0] pa, logic [63:0] pb);
        logic [63:0] r = '0;
        int s = int'(c[6:4]);
        if (s > 4) s = 4;
        for (int b = 0; b < 64; b++) r[b] = (b / 16) < s;
        if (c[0]) r = r & ~(c[1] ? pb : pa);
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) m_tag[i] = 2'b01;
            m_key = '0; m_pa = '0; m_pb = '0; m_ctrl = 7'h40;
            m_tgt = 0; m_taddr = 0; m_src = 0; m_saddr = 0;
            m_pend = 0; m_match = 0; m_multi = 0; m_addr = '0; m_dout = '0;
        end else begin
            m_care = model_care(m_ctrl, m_pa, m_pb);
            if (en && wr_n && !cmd_n) m_dout = {54'd0, m_multi, m_match, m_addr};
            else if (en && wr_n && cmd_n) begin
                case (m_src)
                    0: m_dout = m_key;
                    1: m_dout = m_pa;
                    2: m_dout = m_pb;
                    3: m_dout = {57'd0, m_ctrl};
                    4: m_dout = m_mem[m_saddr];
                    5: m_dout = m_match ? (m_mem[m_addr] & ~m_care) : 64'd0;
                    default: m_dout = '0;
                endcase
            end
            if (m_pend) begin
                m_found = 0; m_multi = 0; m_addr = '0;
                for (int i = 0; i < 256; i++) begin
                    if (m_tag[i] == 2'b00 && ((m_mem[i] ^ m_key) & m_care) == 64'd0) begin
                        if (!m_found) begin m_found = 1; m_addr = 8'(i); end
                        else m_multi = 1;
                    end
                end
                m_match = m_found;
            end
            m_newpend = 0;
            if (en && !wr_n && !cmd_n) begin
                case (int'(din[3:0]))
                    1: begin m_tgt = int'(din[7:4]); m_taddr = int'(din[15:8]); end
                    2: begin m_src = int'(din[7:4]); m_saddr = int'(din[15:8]); end
                    3: m_newpend = 1;
                    4: m_tag[din[15:8]] = din[17:16];
                    default: ;
                endcase
            end
            if (en && !wr_n && cmd_n) begin
                case (m_tgt)
                    0: begin m_key = din; m_newpend = 1; end
                    1: begin m_pa = din; m_newpend = 1; end
                    2: begin m_pb = din; m_newpend = 1; end
                    3: begin m_ctrl = din[6:0]; m_newpend = 1; end
                    4: begin
                        m_keep = m_ctrl[2] ? (m_ctrl[3] ? m_pb : m_pa) : 64'd0;
                        m_mem[m_taddr] = (m_mem[m_taddr] & m_keep) | (din & ~m_keep);
                    end
                    default: ;
                endcase
            end
            m_pend = m_newpend;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if ({match_o, multi_o, addr_o} !== {m_match, m_multi, m_addr}) begin
                fails++;
                $display("FAIL %s status got=%b/%b/%0d exp=%b/%b/%0d", phase,
                         match_o, multi_o, addr_o, m_match, m_multi, m_addr);
            end
            checks++;
            if (dout !== m_dout) begin
                fails++;
                $display("FAIL %s dout got=%h exp=%h", phase, dout, m_dout);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] cw(int op, int sel, int a, int t);
        return 64'(op & 15) | (64'(sel & 15) << 4) | (64'(a & 255) << 8) | (64'(t & 3) << 16);
    endfunction

    task automatic cyc(input bit e, input bit w, input bit c, input logic [63:0] d);
        @(negedge clk);
        en = e; wr_n = w; cmd_n = c; din = d;
    endtask

    task automatic wr_cmd(input logic [63:0] d); cyc(1, 0, 0, d); endtask
    task automatic wr_dat(input logic [63:0] d); cyc(1, 0, 1, d); endtask
    task automatic idle(); cyc(0, 1, 1, 64'd0); endtask

    task automatic put_entry(input int a, input logic [63:0] v);
        wr_cmd(cw(1, 4, a, 0)); wr_dat(v);
    endtask
    task automatic set_tag(input int a, input int t); wr_cmd(cw(4, 0, a, t)); endtask
    task automatic set_reg(input int sel, input logic [63:0] v);
        wr_cmd(cw(1, sel, 0, 0)); wr_dat(v);
    endtask
    task automatic read_src(input int sel, input int a);
        wr_cmd(cw(2, sel, a, 0)); cyc(1, 1, 1, 64'd0); idle();
    endtask
    task automatic read_stat(); cyc(1, 1, 0, 64'd0); idle(); endtask
    task automatic settle(); idle(); idle(); idle(); endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    localparam logic [63:0] V = 64'h0123_4567_89AB_CDEF;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        settle();
        phase = "R1 reset";
        chk("R1 status", {61'd0, match_o, multi_o, addr_o == 8'd0}, 64'd1);
        read_src(3, 0);
        chk("R1 ctrl", dout, 64'h40);
        read_stat();
        chk("R1 status word", dout, 64'd0);

        phase = "R12 entry load";
        put_entry(5, V); put_entry(9, V); put_entry(20, V ^ 64'hFFFF_0000_0000_0000);
        put_entry(21, 64'h0000_0000_0000_CDEF);
        put_entry(30, V); put_entry(31, V); put_entry(32, V);
        set_tag(5, 0); set_tag(9, 0); set_tag(20, 0); set_tag(21, 0);
        set_tag(30, 2); set_tag(31, 3);
        settle();
        chk("R4 no search on entry write", {62'd0, match_o, multi_o}, 64'd0);

        phase = "R4 R7 key write";
        set_reg(0, V); settle();
        chk("R7 lowest index", {54'd0, multi_o, match_o, addr_o}, {54'd0, 1'b1, 1'b1, 8'd5});
        read_stat();
        chk("R2 status word", dout, 64'h305);

        phase = "R3 R5 tags";
        set_tag(5, 2); wr_cmd(cw(3, 0, 0, 0)); settle();
        chk("R3 parked skipped", {54'd0, multi_o, match_o, addr_o}, {54'd0, 1'b0, 1'b1, 8'd9});
        set_tag(9, 3); wr_cmd(cw(3, 0, 0, 0)); settle();
        chk("R3 storage skipped", {63'd0, match_o}, 64'd0);

        phase = "R8 search mask";
        set_reg(1, 64'hFFFF_0000_0000_0000); set_reg(3, 64'h41); settle();
        chk("R8 masked hit", {54'd0, multi_o, match_o, addr_o}, {54'd0, 1'b0, 1'b1, 8'd20});
        read_src(5, 0);
        chk("R11 payload mask", dout, 64'hFEDC_0000_0000_0000);

        phase = "R10 lanes";
        set_reg(3, 64'h10); settle();
        chk("R10 one lane", {54'd0, multi_o, match_o, addr_o}, {54'd0, 1'b1, 1'b1, 8'd20});
        read_src(5, 0);
        chk("R11 payload lanes", dout, 64'hFEDC_4567_89AB_0000);
        set_reg(0, 64'h5555_5555_5555_5555); set_reg(3, 64'h00); settle();
        chk("R10 zero lanes", {54'd0, multi_o, match_o, addr_o}, {54'd0, 1'b1, 1'b1, 8'd20});

        phase = "R9 write guard";
        set_reg(2, 64'h0000_0000_0000_FFFF); set_reg(3, 64'h4C);
        put_entry(21, 64'hAAAA_BBBB_CCCC_DDDD);
        read_src(4, 21);
        chk("R9 guarded write", dout, 64'hAAAA_BBBB_CCCC_CDEF);

        phase = "R12 storage entry";
        read_src(4, 31);
        chk("R12 read by index", dout, V);
        set_reg(3, 64'h40);
        put_entry(31, 64'h00FF_00FF_00FF_00FF);
        read_src(4, 31);
        chk("R12 write by index", dout, 64'h00FF_00FF_00FF_00FF);

        phase = "R2 ignored";
        read_stat();
        wr_cmd(cw(15, 0, 0, 0)); cyc(0, 1, 1, 64'd0); cyc(0, 0, 0, 64'd3); settle();
        chk("R2 bogus opcode and idle strobes", dout, {54'd0, multi_o, match_o, addr_o});

        phase = "R6 random traffic";
        for (int i = 0; i < 8; i++) put_entry(i, 64'h0123_4567_89AB_0000 | 64'(i % 3));
        for (int n = 0; n < 600; n++) begin
            int k = $urandom % 10;
            int a = $urandom % 8;
            logic [63:0] v = 64'h0123_4567_89AB_0000 | 64'($urandom % 4);
            case (k)
                0: put_entry(a, v);
                1: set_tag(a, $urandom % 4);
                2: set_reg(0, v);
                3: set_reg(3, 64'($urandom % 128));
                4: set_reg(1 + ($urandom % 2), {$urandom, $urandom});
                5: wr_cmd(cw(3, 0, 0, 0));
                6: cyc(1, 1, 0, 64'd0);
                7: begin wr_cmd(cw(2, $urandom % 7, a, 0)); cyc(1, 1, 1, 64'd0); end
                8: wr_cmd(cw(5 + ($urandom % 11), 0, a, 0));
                default: idle();
            endcase
        end
        settle();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=finish");
        finish_run();
    end
endmodule